// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Port

A watchdog peripheral that sits on an APB slave port. A down-counter, advanced by a separate tick-enable input, reloads from a programmable value. When it runs out the first time, the block raises an interrupt flag and reloads. If it runs out again before software has cleared that flag, the block latches a reset request and stops counting. Software services the watchdog by writing the interrupt-clear register, which drops the flag and restarts the countdown from the reload value.

Register writes can be frozen by a lock register that only a fixed 32-bit key opens. A pair of integration-test registers can take over both outputs so that board-level wiring can be checked. Read-only identification bytes sit at the top of the 4 KiB window.

The parameter `STICKY_CTRL` selects an alternate flavour. In it, the control register ignores writes once interrupts have been enabled, and the integration-test registers are absent.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset, the load value and the counter both read 0xFFFFFFFF. Control, raw flag, reset flag, lock, integration control and integration output are 0, both outputs are low, and the counter counts on ticks.
- R2: Writing byte offset 0x000 sets the reload value and the counter to the written data and enables counting. Offset 0x000 reads the reload value and offset 0x004 reads the counter.
- R3: The counter decrements by one only on cycles with `tick_en` high. When it steps from 1 to 0 with the raw flag clear, the raw flag (offset 0x010, bit 0) sets and the counter reloads.
- R4: When the counter steps from 1 to 0 with the raw flag already set, the reset flag sets and the counter stops at 0. The reset flag is cleared only by reset.
- R5: A write of any data to offset 0x00C clears the raw flag and reloads the counter from the reload value.
- R6: Control (offset 0x008) keeps bit 0 (interrupt enable) and bit 1 (reset enable) and drops all other bits. `irq_o` is the raw flag AND bit 0, `rst_req_o` is the reset flag AND bit 1, and offset 0x014 reads the masked interrupt.
- R7: A write to offset 0xC00 clears the lock when the data is 0x1ACCE551 and sets it otherwise. Offset 0xC00 reads 1 while locked. While locked, writes to every other offset are ignored.
- R8: When integration control (offset 0xF00, bit 0) is set, `irq_o` follows bit 1 and `rst_req_o` follows bit 0 of integration output (offset 0xF04).
- R9: Offsets 0xFD0 to 0xFFC, in steps of 4, read the bytes 0x04, 0x00, 0x00, 0x00, 0x24, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R10: Reads of offsets 0x00C and 0xF04, and of unmapped offsets, return 0. Writes to offsets 0x004, 0x010, 0x014 and the identification offsets change nothing.
- R11: A counter that holds 0, including after a load of 0, never raises either flag.
- R12: With `STICKY_CTRL`=1, control writes are ignored once bit 0 of control is set. In that flavour, offsets 0xF00 and 0xF04 read 0 and writes to them have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable; the counter steps on cycles where it is high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 10 | APB word address (byte address bits 11:2) |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero wait states |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
The bench sweeps small reload values from 1 upward, counting ticks arithmetically. Off-by-one expiry would show as a wrong counter value one tick before or after the flag rises. A design that did not stop after the second expiry would show a counter that keeps wrapping after the reset request. Clearing between expiries must restart the first stage; a design that kept a hidden expiry count would assert the reset request too early. The bench also covers near-miss lock keys, writes to read-only offsets and a loaded zero; a design that decoded these loosely would leave registers changed or flags raised. The alternate flavour runs in parallel on the same bus, so a control write that slips past its enable freeze shows up as a divergence from the expected value.

// File: rtl/dual_stage_wdt.sv
`timescale 1ns/1ps
module dual_stage_wdt #(
  parameter int          CNT_W       = 32,
  parameter bit          STICKY_CTRL = 1'b0,
  parameter logic [31:0] UNLOCK_KEY  = 32'h1ACCE551
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [9:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam logic [9:0] A_LOAD = 10'h000, A_VAL  = 10'h001, A_CTRL = 10'h002,
                         A_ICLR = 10'h003, A_RIS  = 10'h004, A_MIS  = 10'h005,
                         A_LOCK = 10'h300, A_ITCR = 10'h3C0, A_ITOP = 10'h3C1,
                         A_ID0  = 10'h3F4;
  localparam bit             HAS_IT = !STICKY_CTRL;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] load_q, cnt_q;
  logic [1:0]       ctrl_q, itop_q;
  logic             run_q, raw_q, rstf_q, lock_q, itcr_q;

  wire wr     = psel & penable & pwrite;
  wire wr_ok  = wr & ~lock_q;
  wire reload = wr_ok & ((paddr == A_LOAD) | (paddr == A_ICLR));

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'h4:    return 8'h04;
      4'h8:    return 8'h24;
      4'h9:    return 8'hB8;
      4'hA:    return 8'h1B;
      4'hC:    return 8'h0D;
      4'hD:    return 8'hF0;
      4'hE:    return 8'h05;
      4'hF:    return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '1;
      cnt_q  <= '1;
      run_q  <= 1'b1;
      ctrl_q <= '0;
      raw_q  <= 1'b0;
      rstf_q <= 1'b0;
      lock_q <= 1'b0;
      itcr_q <= 1'b0;
      itop_q <= '0;
    end else begin
      if (wr && paddr == A_LOCK) lock_q <= (pwdata != UNLOCK_KEY);
      if (wr_ok) begin
        case (paddr)
          A_LOAD: begin
            load_q <= pwdata[CNT_W-1:0];
            cnt_q  <= pwdata[CNT_W-1:0];
            run_q  <= 1'b1;
          end
          A_CTRL: if (!(STICKY_CTRL && ctrl_q[0])) ctrl_q <= pwdata[1:0];
          A_ICLR: begin
            raw_q <= 1'b0;
            cnt_q <= load_q;
          end
          A_ITCR: if (HAS_IT) itcr_q <= pwdata[0];
          A_ITOP: if (HAS_IT) itop_q <= pwdata[1:0];
          default: ;
        endcase
      end
      if (tick_en && run_q && !reload) begin
        if (cnt_q == ONE) begin
          if (!raw_q) begin
            raw_q <= 1'b1;
            cnt_q <= load_q;
          end else begin
            rstf_q <= 1'b1;
            cnt_q  <= '0;
            run_q  <= 1'b0;
          end
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr >= A_ID0) prdata = {24'h0, id_byte(paddr[3:0])};
    else
      case (paddr)
        A_LOAD: prdata = 32'(load_q);
        A_VAL:  prdata = 32'(cnt_q);
        A_CTRL: prdata = {30'h0, ctrl_q};
        A_RIS:  prdata = {31'h0, raw_q};
        A_MIS:  prdata = {31'h0, raw_q & ctrl_q[0]};
        A_LOCK: prdata = {31'h0, lock_q};
        A_ITCR: prdata = {31'h0, itcr_q};
        default: prdata = '0;
      endcase
  end

  assign irq_o     = itcr_q ? itop_q[1] : (raw_q & ctrl_q[0]);
  assign rst_req_o = itcr_q ? itop_q[0] : (rstf_q & ctrl_q[1]);
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(parameter int CNT_W = 32) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [9:0]       paddr,
  input logic [31:0]      pwdata,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic [1:0]       ctrl,
  input logic             raw,
  input logic             rstf,
  input logic             lock,
  input logic             run,
  input logic             itcr
);
  localparam logic [9:0] A_LOAD = 10'h000, A_ICLR = 10'h003, A_LOCK = 10'h300;
  wire wr = psel & penable & pwrite;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !lock && paddr == A_LOAD |=> cnt == $past(pwdata[CNT_W-1:0]) && load == $past(pwdata[CNT_W-1:0]) && run);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !wr |=> $stable(cnt));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr && run && tick_en && cnt > CNT_W'(1) |=> cnt == $past(cnt) - CNT_W'(1));

  p_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr && run && tick_en && cnt == CNT_W'(1) && !raw |=> raw && cnt == $past(load) && !rstf == !$past(rstf));

  p_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr && run && tick_en && cnt == CNT_W'(1) && raw |=> rstf && !run && cnt == '0);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rstf |=> rstf);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !lock && paddr == A_ICLR |=> !raw && cnt == $past(load));

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !itcr && !(raw && ctrl[0]) |-> !irq_o);

  p_rst_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !itcr && !(rstf && ctrl[1]) |-> !rst_req_o);

  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock && wr && paddr != A_LOCK |=> $stable(ctrl) && $stable(load));

  p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr && cnt == '0 |=> $stable(raw) && $stable(rstf));
endmodule

bind dual_stage_wdt wdt_checker #(.CNT_W(CNT_W)) u_wdt_checker (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .irq_o(irq_o),
  .rst_req_o(rst_req_o), .cnt(cnt_q), .load(load_q), .ctrl(ctrl_q), .raw(raw_q),
  .rstf(rstf_q), .lock(lock_q), .run(run_q), .itcr(itcr_q));

// File: tb/test_dual_stage_wdt.sv
`timescale 1ns/1ps
module test_dual_stage_wdt;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata2;
  logic irq_o, rst_req_o, irq2, rst2;
  int n_vec = 0, n_bad = 0;
  logic [31:0] rd, rd2;
  localparam logic [31:0] KEY = 32'h1ACCE551;
  logic [7:0] id_exp [12];

  always #10 clk = ~clk;

  dual_stage_wdt i_dual_stage_wdt (.clk, .rst_n, .tick_en, .psel, .penable, .pwrite,
    .paddr, .pwdata, .prdata, .irq_o, .rst_req_o);
  dual_stage_wdt #(.STICKY_CTRL(1'b1)) i_dual_stage_wdt_alt (.clk, .rst_n, .tick_en,
    .psel, .penable, .pwrite, .paddr, .pwdata, .prdata(prdata2), .irq_o(irq2),
    .rst_req_o(rst2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a[11:2]; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rdw(input logic [11:0] a);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a[11:2];
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; rd2 = prdata2;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    id_exp = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h24, 8'hB8, 8'h1B, 8'h00,
               8'h0D, 8'hF0, 8'h05, 8'hB1};

    // R1 reset state
    do_reset();
    rdw(12'h000); chk("R1 load", rd, 32'hFFFF_FFFF);
    rdw(12'h004); chk("R1 value", rd, 32'hFFFF_FFFF);
    rdw(12'h008); chk("R1 ctrl", rd, 0);
    rdw(12'h010); chk("R1 raw", rd, 0);
    rdw(12'hC00); chk("R1 lock", rd, 0);
    rdw(12'hF00); chk("R1 itcr", rd, 0);
    chk("R1 irq", {31'h0, irq_o}, 0);
    chk("R1 rst", {31'h0, rst_req_o}, 0);
    tick(5);
    rdw(12'h004); chk("R1 counting", rd, 32'hFFFF_FFFA);

    // R2 R3 R4 sweep of reload values
    for (int l = 1; l <= 6; l++) begin
      do_reset();
      wr(12'h008, 3);
      wr(12'h000, l);
      rdw(12'h000); chk("R2 load readback", rd, l);
      rdw(12'h004); chk("R2 value after load", rd, l);
      tick(l - 1);
      rdw(12'h004); chk("R3 one before expiry", rd, 1);
      rdw(12'h010); chk("R3 raw before expiry", rd, 0);
      tick(1);
      rdw(12'h010); chk("R3 raw after expiry", rd, 1);
      rdw(12'h004); chk("R3 reload", rd, l);
      chk("R3 irq", {31'h0, irq_o}, 1);
      chk("R4 no reset yet", {31'h0, rst_req_o}, 0);
      tick(l);
      chk("R4 reset req", {31'h0, rst_req_o}, 1);
      rdw(12'h004); chk("R4 stopped at 0", rd, 0);
      tick(3);
      rdw(12'h004); chk("R4 stays stopped", rd, 0);
      chk("R4 reset held", {31'h0, rst_req_o}, 1);
    end

    // R5 clear between expiries, R6 masking
    do_reset();
    wr(12'h008, 1);
    wr(12'h000, 4);
    tick(4);
    rdw(12'h010); chk("R5 raw set", rd, 1);
    wr(12'h00C, 32'hDEAD_BEEF);
    rdw(12'h010); chk("R5 raw cleared", rd, 0);
    rdw(12'h004); chk("R5 reload", rd, 4);
    chk("R5 irq low", {31'h0, irq_o}, 0);
    tick(4);
    chk("R5 first stage again", {31'h0, irq_o}, 1);
    tick(4);
    chk("R6 reset masked", {31'h0, rst_req_o}, 0);
    for (int c = 0; c < 4; c++) begin
      wr(12'h008, 32'hFFFF_FFF0 | c);
      rdw(12'h008); chk("R6 ctrl bits", rd, c);
      chk("R6 irq", {31'h0, irq_o}, c & 1);
      chk("R6 rst", {31'h0, rst_req_o}, (c >> 1) & 1);
      rdw(12'h014); chk("R6 masked", rd, c & 1);
      rdw(12'h010); chk("R6 raw", rd, 1);
    end

    // R7 lock
    do_reset();
    wr(12'h000, 100);
    wr(12'hC00, 32'h1234_5678);
    rdw(12'hC00); chk("R7 locked", rd, 1);
    wr(12'h000, 5);
    rdw(12'h000); chk("R7 load blocked", rd, 100);
    wr(12'h008, 3);
    rdw(12'h008); chk("R7 ctrl blocked", rd, 0);
    wr(12'hC00, KEY);
    rdw(12'hC00); chk("R7 unlocked", rd, 0);
    wr(12'h000, 5);
    rdw(12'h000); chk("R7 load accepted", rd, 5);
    begin
      logic [31:0] keys [5];
      keys = '{KEY ^ 32'h1, 32'h0, KEY << 1, 32'hFFFF_FFFF, KEY};
      for (int k = 0; k < 5; k++) begin
        wr(12'hC00, keys[k]);
        rdw(12'hC00); chk("R7 key sweep", rd, (keys[k] != KEY) ? 1 : 0);
      end
    end
    wr(12'h008, 1);
    wr(12'h000, 2);
    tick(2);
    wr(12'hC00, 0);
    wr(12'h00C, 0);
    rdw(12'h010); chk("R7 clear blocked", rd, 1);
    chk("R7 irq kept", {31'h0, irq_o}, 1);

    // R8 integration override, R12 alt flavour lacks it
    do_reset();
    wr(12'hF00, 1);
    rdw(12'hF00); chk("R8 itcr readback", rd, 1);
    chk("R12 alt itcr unmapped", rd2, 0);
    for (int o = 0; o < 4; o++) begin
      wr(12'hF04, o);
      chk("R8 irq follows", {31'h0, irq_o}, (o >> 1) & 1);
      chk("R8 rst follows", {31'h0, rst_req_o}, o & 1);
      chk("R12 alt irq unaffected", {31'h0, irq2}, 0);
      chk("R12 alt rst unaffected", {31'h0, rst2}, 0);
    end
    rdw(12'hF04); chk("R10 itop reads 0", rd, 0);
    wr(12'hF00, 0);
    chk("R8 back to normal", {31'h0, irq_o | rst_req_o}, 0);

    // R9 identification
    for (int i = 0; i < 12; i++) begin
      rdw(12'hFD0 + 12'(4 * i));
      chk("R9 id", rd, {24'h0, id_exp[i]});
    end

    // R10 write-only, unmapped, read-only
    do_reset();
    wr(12'h000, 50);
    begin
      logic [11:0] holes [5];
      holes = '{12'h00C, 12'h018, 12'h800, 12'hFCC, 12'hF08};
      for (int h = 0; h < 5; h++) begin
        rdw(holes[h]); chk("R10 reads zero", rd, 0);
      end
    end
    wr(12'h004, 7);
    wr(12'h010, 1);
    wr(12'h014, 1);
    wr(12'hFE0, 32'h55);
    rdw(12'h004); chk("R10 value not written", rd, 50);
    rdw(12'h000); chk("R10 load intact", rd, 50);
    rdw(12'h010); chk("R10 raw not written", rd, 0);
    rdw(12'hFE0); chk("R10 id intact", rd, 32'h24);

    // R11 zero load never expires
    do_reset();
    wr(12'h008, 3);
    wr(12'h000, 0);
    tick(5);
    rdw(12'h004); chk("R11 value 0", rd, 0);
    rdw(12'h010); chk("R11 no raw", rd, 0);
    chk("R11 no irq", {31'h0, irq_o | rst_req_o}, 0);

    // R12 sticky control in alt flavour
    do_reset();
    wr(12'h008, 2);
    rdw(12'h008); chk("R12 alt ctrl before enable", rd2, 2);
    wr(12'h008, 0);
    rdw(12'h008); chk("R12 alt ctrl cleared", rd2, 0);
    wr(12'h008, 1);
    wr(12'h008, 0);
    rdw(12'h008);
    chk("R12 alt ctrl frozen", rd2, 1);
    chk("R12 main ctrl writable", rd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule